// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one integer by another over several clock cycles, one quotient bit per cycle, with the restoring method. A one-cycle `start` pulse captures a dividend, a divisor and a mode select that picks unsigned or two's-complement signed operands. Once the operation is complete, the low result register holds the quotient and the high result register holds the remainder.

Each iteration shifts the partial remainder left by one place and brings in the next dividend bit. It then subtracts the divisor as a trial. A negative difference yields quotient bit 0 and the shifted value is kept. Any other difference yields quotient bit 1 and the difference is kept. The shift is part of the register's next-value path, so no cycle is spent on it alone. The dividend and the growing quotient share one register, and quotient bits enter at its low end as dividend bits leave at its top. In signed mode the operands are reduced to magnitudes and divided. Then one final cycle corrects the signs: the quotient is negated when the operand signs differ, and the remainder takes the sign of the dividend.

A zero divisor does not start an iteration. It completes on the next cycle with a divide-by-zero flag and leaves both result registers as they were.

Top module: `rdiv_top`

## Requirements
- R1: After reset, `busy`, `done` and `div_zero` are 0 and `res_hi` and `res_lo` are all zeros.
- R2: With `is_signed` = 0, at completion `res_lo` equals floor(dividend / divisor) and `res_hi` equals dividend mod divisor, both taken as unsigned WIDTH-bit numbers.
- R3: With `is_signed` = 1, the operands are read as two's complement. `res_lo` holds the quotient truncated toward zero, negated when the operand signs differ, and kept to its low WIDTH bits, so the most negative value divided by -1 returns the most negative value.
- R4: With `is_signed` = 1, `res_hi` holds a remainder whose magnitude is below the divisor magnitude and whose sign is the dividend's sign (or which is zero), so that dividend = quotient * divisor + remainder.
- R5: A start with a nonzero divisor, accepted while `busy` = 0, raises `busy` in the next cycle. `busy` stays high for exactly WIDTH + 1 cycles: WIDTH iteration cycles and one sign-correction cycle.
- R6: `done` rises in the first cycle with `busy` low after an operation, lasts one cycle, and is the only cycle in which `res_hi` and `res_lo` may change.
- R7: A start with a zero divisor, accepted while `busy` = 0, gives `done` = 1 and `div_zero` = 1 in the next cycle, never raises `busy`, and leaves `res_hi` and `res_lo` unchanged.
- R8: A `start` pulse while `busy` = 1 is ignored. The running operation keeps its operands and its latency.
- R9: `div_zero` is 0 whenever `done` reports a division by a nonzero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a division |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| dividend | input | WIDTH | Dividend, sampled with `start` |
| divisor | input | WIDTH | Divisor, sampled with `start` |
| busy | output | 1 | High while an operation is running |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Set with `done` when the divisor was zero |
| res_hi | output | WIDTH | Remainder |
| res_lo | output | WIDTH | Quotient |

## Verification
If a partial-remainder bit or a quotient bit goes wrong in one iteration, the error propagates into the result: for a fixed divisor, the printed values for a whole run of dividends will be wrong, and this shows in `res_lo`/`res_hi` on the `done` cycle of that very operation. A counter that is off by one shows as a `busy` window one cycle too long or too short, and it also shifts the quotient by one bit position, so both the latency check and the value check catch it. A sign-correction fault shows only in signed mode, in the quadrants where the signs differ or the dividend is negative, so the sweep covers every combination of operand signs as well as the most-negative operand.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIX  = 2'd2
  } rdiv_state_e;
endpackage

// File: rtl/rdiv_cneg.sv
// Conditional two's-complement negation, used both to take operand
// magnitudes and to restore result signs.
module rdiv_cneg #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             neg_i,
  output logic [WIDTH-1:0] val_o
);
  always_comb begin
    if (neg_i) val_o = ~val_i + WIDTH'(1);
    else       val_o = val_i;
  end
endmodule

// File: rtl/rdiv_step.sv
// One restoring iteration: shift the partial remainder left by one place,
// taking the top bit of the dividend/quotient register, then make a trial
// subtraction.
module rdiv_step #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] part_i,
  input  logic [WIDTH-1:0] dq_i,
  input  logic [WIDTH-1:0] dvsr_i,
  output logic [WIDTH-1:0] part_o,
  output logic [WIDTH-1:0] dq_o
);
  logic [WIDTH:0] shifted;
  logic [WIDTH:0] trial;
  logic           below;

  assign shifted = {part_i, dq_i[WIDTH-1]};
  assign trial   = shifted - {1'b0, dvsr_i};
  assign below   = trial[WIDTH];

  assign part_o = below ? shifted[WIDTH-1:0] : trial[WIDTH-1:0];
  assign dq_o   = {dq_i[WIDTH-2:0], ~below};
endmodule

// File: rtl/rdiv_ctrl.sv
// Sequencer: idle, WIDTH iteration cycles, one sign-correction cycle.
module rdiv_ctrl
  import rdiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic dvsr_zero_i,
  output logic load_o,
  output logic zero_o,
  output logic step_o,
  output logic fix_o,
  output logic busy_o
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  rdiv_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic          accept;

  assign accept = start_i && (state_q == ST_IDLE);
  assign load_o = accept && !dvsr_zero_i;
  assign zero_o = accept && dvsr_zero_i;
  assign step_o = (state_q == ST_ITER);
  assign fix_o  = (state_q == ST_FIX);
  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (load_o) state_q <= ST_ITER;
        end
        ST_ITER: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == LAST) state_q <= ST_FIX;
        end
        ST_FIX: begin
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdiv_top.sv
module rdiv_top #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             is_signed,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic             div_zero,
  output logic [WIDTH-1:0] res_hi,
  output logic [WIDTH-1:0] res_lo
);
  logic             load, zero_req, step, fix;
  logic             a_neg, b_neg;
  logic [WIDTH-1:0] a_mag, b_mag;
  logic [WIDTH-1:0] part_q, dq_q, dvsr_q;
  logic [WIDTH-1:0] part_nx, dq_nx;
  logic [WIDTH-1:0] quo_fixed, rem_fixed;
  logic             neg_quo_q, neg_rem_q;
  logic             done_q, dz_q;
  logic [WIDTH-1:0] hi_q, lo_q;

  assign a_neg = is_signed && dividend[WIDTH-1];
  assign b_neg = is_signed && divisor[WIDTH-1];

  rdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .dvsr_zero_i(divisor == '0),
    .load_o     (load),
    .zero_o     (zero_req),
    .step_o     (step),
    .fix_o      (fix),
    .busy_o     (busy)
  );

  rdiv_cneg #(.WIDTH(WIDTH)) u_mag_dividend (
    .val_i(dividend), .neg_i(a_neg), .val_o(a_mag)
  );
  rdiv_cneg #(.WIDTH(WIDTH)) u_mag_divisor (
    .val_i(divisor), .neg_i(b_neg), .val_o(b_mag)
  );

  rdiv_step #(.WIDTH(WIDTH)) u_step (
    .part_i(part_q),
    .dq_i  (dq_q),
    .dvsr_i(dvsr_q),
    .part_o(part_nx),
    .dq_o  (dq_nx)
  );

  rdiv_cneg #(.WIDTH(WIDTH)) u_fix_quo (
    .val_i(dq_q), .neg_i(neg_quo_q), .val_o(quo_fixed)
  );
  rdiv_cneg #(.WIDTH(WIDTH)) u_fix_rem (
    .val_i(part_q), .neg_i(neg_rem_q), .val_o(rem_fixed)
  );

  // Datapath registers
  always_ff @(posedge clk) begin
    if (rst) begin
      part_q    <= '0;
      dq_q      <= '0;
      dvsr_q    <= '0;
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
    end else if (load) begin
      part_q    <= '0;
      dq_q      <= a_mag;
      dvsr_q    <= b_mag;
      neg_quo_q <= a_neg ^ b_neg;
      neg_rem_q <= a_neg;
    end else if (step) begin
      part_q <= part_nx;
      dq_q   <= dq_nx;
    end
  end

  // Registered results and flags
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      lo_q   <= '0;
      done_q <= 1'b0;
      dz_q   <= 1'b0;
    end else begin
      done_q <= fix || zero_req;
      dz_q   <= zero_req;
      if (fix) begin
        lo_q <= quo_fixed;
        hi_q <= rem_fixed;
      end
    end
  end

  assign done     = done_q;
  assign div_zero = dz_q;
  assign res_hi   = hi_q;
  assign res_lo   = lo_q;
endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [WIDTH-1:0] divisor,
  input logic             busy,
  input logic             done,
  input logic             div_zero,
  input logic [WIDTH-1:0] res_hi,
  input logic [WIDTH-1:0] res_lo
);
  int unsigned busy_run;

  always_ff @(posedge clk) begin
    if (rst) busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else busy_run <= 0;
  end

  assert_start_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (divisor != '0)) |=> busy);

  assert_busy_len_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_run == WIDTH + 1));

  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !div_zero) |-> $fell(busy));

  assert_results_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(res_hi) && $stable(res_lo)));

  assert_zero_fast_R7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (divisor == '0)) |=> (done && div_zero && !busy));

  assert_zero_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    div_zero |-> ($stable(res_hi) && $stable(res_lo)));

  assert_flag_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    div_zero |-> done);
endmodule

bind rdiv_top rdiv_checker #(.WIDTH(WIDTH)) u_rdiv_checker (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .divisor (divisor),
  .busy    (busy),
  .done    (done),
  .div_zero(div_zero),
  .res_hi  (res_hi),
  .res_lo  (res_lo)
);

// File: tb/rdiv_top_tb_top.sv
`timescale 1ns/1ps
module rdiv_top_tb_top;
  localparam int W = 6;
  localparam int MASK = (1 << W) - 1;
  localparam int LIMIT = 190000;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic         is_signed;
  logic [W-1:0] dividend, divisor;
  logic         busy, done, div_zero;
  logic [W-1:0] res_hi, res_lo;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  rdiv_top #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .div_zero(div_zero),
    .res_hi(res_hi), .res_lo(res_lo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sval(input int v, input bit sgn);
    if (sgn && v[W-1]) return v - (1 << W);
    return v;
  endfunction

  // One operation; if interrupt is set, a second start with other operands
  // is pulsed in the middle of the run and must be ignored.
  task automatic run_op(input int a, input int b, input bit sgn, input bit interrupt);
    int sa, sb, q, r, n;
    logic [W-1:0] prev_hi, prev_lo;
    sa = sval(a, sgn);
    sb = sval(b, sgn);
    prev_hi = res_hi;
    prev_lo = res_lo;
    @(negedge clk);
    start = 1'b1; is_signed = sgn;
    dividend = W'(a); divisor = W'(b);
    @(negedge clk);
    start = 1'b0;
    if (b == 0) begin
      chk(done && div_zero && !busy, "R7 zero divisor flags", {done, div_zero, busy}, 3'b110);
      chk(res_hi == prev_hi && res_lo == prev_lo, "R7 results kept",
          {res_hi, res_lo}, {prev_hi, prev_lo});
      return;
    end
    n = 0;
    while (busy && n < 4 * W) begin
      n++;
      if (interrupt && n == 3) begin
        start = 1'b1; dividend = W'(a ^ 21); divisor = W'(b ^ 5); is_signed = ~sgn;
      end else begin
        start = 1'b0;
      end
      chk(!done, "R6 done low while busy", done, 0);
      @(negedge clk);
    end
    start = 1'b0;
    chk(n == W + 1, "R5 busy length", n, W + 1);
    chk(done == 1'b1 && div_zero == 1'b0, "R9 done without zero flag",
        {done, div_zero}, 2'b10);
    q = sa / sb;
    r = sa % sb;
    if (!sgn) begin
      chk(int'(res_lo) == (q & MASK), "R2 unsigned quotient", res_lo, q & MASK);
      chk(int'(res_hi) == (r & MASK), "R2 unsigned remainder", res_hi, r & MASK);
    end else begin
      chk(int'(res_lo) == (q & MASK), "R3 signed quotient", res_lo, q & MASK);
      chk(int'(res_hi) == (r & MASK), "R4 signed remainder", res_hi, r & MASK);
      chk(r == 0 || ((r < 0) == (sa < 0)), "R4 remainder sign", r, sa);
    end
    if (interrupt) chk(1'b1, "R8 ignored start (values above)", 0, 0);
    @(negedge clk);
    chk(!done, "R6 done single cycle", done, 0);
  endtask

  initial begin
    while (cycles < LIMIT) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, LIMIT);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; is_signed = 1'b0;
    dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !div_zero, "R1 reset flags", {busy, done, div_zero}, 0);
    chk(res_hi == '0 && res_lo == '0, "R1 reset results", {res_hi, res_lo}, 0);

    // R7 zero divisor straight after reset
    run_op(13, 0, 1'b0, 1'b0);
    run_op(5, 3, 1'b0, 1'b0);
    run_op(40, 0, 1'b1, 1'b0);

    // R8 start during busy is ignored
    run_op(45, 7, 1'b0, 1'b1);
    run_op(50, 9, 1'b1, 1'b1);

    // R3 most negative by -1 wraps
    run_op(32, 63, 1'b1, 1'b0);

    // Exhaustive sweep: R2, R3, R4, R5, R6, R7, R9
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++)
          run_op(a, b, s[0], 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule